// File: doc/BRIEF.md
# HDLC Transmit DMA Completion Reporter

This block keeps the transmit-side DMA bookkeeping for a set of HDLC channels and turns buffer-completion events into done-queue entries. For each channel it holds an enable bit, a reporting-mode bit, the descriptor being worked on, the current buffer address and the byte count of the last buffer. Three streams come in. Host configuration writes set enable and mode. Pending-descriptor arrivals load a new descriptor pointer and buffer address, and may carry a channel-reset request. Progress events report a finished buffer with its byte count, an end-of-frame flag and an error flag.

In per-packet mode (mode bit 0) a channel writes one done-queue entry per complete packet, and that entry names the packet's first descriptor. In per-buffer mode (mode bit 1) it writes one entry per buffer and codes where that buffer sits in its packet. An error writes one error entry and disables the channel. A later pending descriptor with the reset flag set enables the channel again. Done-queue entries leave through a one-entry valid/ready register. While that register is full and not being drained, the block stops taking progress events.

Top module: `txdr_done_reporter`

## Requirements
- R1: With mode bit 0, an enabled channel produces exactly one entry per packet, when the buffer with end-of-frame set is accepted, with status 000. A packet of one buffer also gives one entry.
- R2: With mode bit 0, the entry carries the descriptor pointer that was current when the packet's first buffer completed, not the descriptor of the final buffer.
- R3: With mode bit 1, every accepted buffer gives one entry carrying the descriptor current at that buffer. Its status is 001 if end-of-frame is clear, 010 if end-of-frame ends a packet of several buffers, and 011 if the buffer is a whole packet by itself.
- R4: A byte count of 8188 or less is stored as the channel's byte count. A count above 8188 (0x1FFC) is rejected: it gives an error entry with status 101 and disables the channel, and the stored count and address stay unchanged.
- R5: An accepted good buffer advances the channel's buffer address by its byte count, modulo 2^32. A pending arrival loads both the address and the descriptor pointer.
- R6: An event with the error flag set gives one entry with status 100 and clears the channel enable. The error flag takes precedence over an oversize count. An error in mid-packet reports the packet's first descriptor, and it ends the packet.
- R7: A pending arrival with the reset flag set sets the channel enable and abandons any packet in progress. A later buffer then starts a new packet.
- R8: An event accepted for a disabled channel produces no entry and leaves that channel's address, count and enable unchanged.
- R9: While an entry is valid and done_ready_i is low, the entry stays stable and evt_ready_o is low. No entry is lost or duplicated.
- R10: When several updates hit one channel in the same cycle, a host write decides enable and mode over a reset request, which in turn beats an error disable. A pending arrival's descriptor and address beat the address advance of a simultaneous event, and that event still uses the previous descriptor.
- R11: After reset every channel is disabled with mode 0, address 0 and count 0, no entry is valid, and evt_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Host configuration write strobe |
| cfg_ch_i | input | CH_W | Channel for the configuration write |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_mode_i | input | 1 | Reporting mode to write (0 per packet, 1 per buffer) |
| pend_valid_i | input | 1 | Pending descriptor arrival |
| pend_ch_i | input | CH_W | Channel of the arrival |
| pend_desc_i | input | DESC_W | Descriptor pointer |
| pend_addr_i | input | ADDR_W | Buffer start address |
| pend_rst_i | input | 1 | Channel-reset request |
| evt_valid_i | input | 1 | Buffer-completion event valid |
| evt_ready_o | output | 1 | Event accepted this cycle when high |
| evt_ch_i | input | CH_W | Channel of the event |
| evt_bytes_i | input | CNT_W | Bytes moved for this buffer |
| evt_eof_i | input | 1 | Buffer ends the packet |
| evt_err_i | input | 1 | Error during this buffer |
| done_valid_o | output | 1 | Done-queue entry valid |
| done_ready_i | input | 1 | Done queue accepts the entry |
| done_ch_o | output | CH_W | Entry channel |
| done_desc_o | output | DESC_W | Entry descriptor pointer |
| done_status_o | output | 3 | Entry status code |
| peek_ch_i | input | CH_W | Channel selected for state observation |
| peek_en_o | output | 1 | Enable of the observed channel |
| peek_addr_o | output | ADDR_W | Buffer address of the observed channel |
| peek_cnt_o | output | CNT_W | Stored byte count of the observed channel |

## Verification
Several updates can land on one channel in the same cycle. An error event can coincide with a reset-flagged pending arrival, a host write can coincide with that arrival, and a good buffer can coincide with a new descriptor load. The bench drives these collisions on purpose. It also fires all four inputs at random over several thousand cycles while holding back done_ready_i at random. A behavioural model applies the priority order and is compared every cycle against the done-queue output and the observed enable, address and count of every channel.

// File: rtl/txdr_pkg.sv
package txdr_pkg;
  localparam logic [2:0] ST_PKT_OK   = 3'b000;
  localparam logic [2:0] ST_BUF_MID  = 3'b001;
  localparam logic [2:0] ST_BUF_END  = 3'b010;
  localparam logic [2:0] ST_BUF_ONE  = 3'b011;
  localparam logic [2:0] ST_ERR_FLAG = 3'b100;
  localparam logic [2:0] ST_ERR_SIZE = 3'b101;
endpackage

// File: rtl/txdr_chan_state.sv
module txdr_chan_state #(
  parameter int DESC_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 13,
  parameter int MAX_BYTES = 8188
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              cfg_mode_i,
  input  logic              pend_we_i,
  input  logic [DESC_W-1:0] pend_desc_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic              pend_rst_i,
  input  logic              evt_we_i,
  input  logic [CNT_W-1:0]  evt_bytes_i,
  input  logic              evt_eof_i,
  input  logic              evt_err_i,
  output logic              en_o,
  output logic              mode_o,
  output logic              busy_o,
  output logic [DESC_W-1:0] first_o,
  output logic [DESC_W-1:0] desc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_BYTES);

  logic hit, bad, good;
  assign hit  = evt_we_i && en_o;
  assign bad  = evt_err_i || (evt_bytes_i > MAX_C);
  assign good = hit && !bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      mode_o  <= 1'b0;
      busy_o  <= 1'b0;
      first_o <= '0;
      desc_o  <= '0;
      addr_o  <= '0;
      cnt_o   <= '0;
    end else begin
      // priority: host write > reset request > error disable
      if (cfg_we_i) begin
        en_o   <= cfg_en_i;
        mode_o <= cfg_mode_i;
      end else if (pend_we_i && pend_rst_i) begin
        en_o <= 1'b1;
      end else if (hit && bad) begin
        en_o <= 1'b0;
      end

      if (pend_we_i && pend_rst_i) busy_o <= 1'b0;
      else if (hit)                busy_o <= !bad && !evt_eof_i;

      if (good && !busy_o && !evt_eof_i) first_o <= desc_o;
      if (good) cnt_o <= evt_bytes_i;

      if (pend_we_i) begin
        desc_o <= pend_desc_i;
        addr_o <= pend_addr_i;
      end else if (good) begin
        addr_o <= addr_o + ADDR_W'(evt_bytes_i);
      end
    end
  end
endmodule

// File: rtl/txdr_entry_gen.sv
module txdr_entry_gen #(
  parameter int DESC_W    = 32,
  parameter int CNT_W     = 13,
  parameter int MAX_BYTES = 8188
) (
  input  logic              fire_i,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              busy_i,
  input  logic [DESC_W-1:0] first_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [CNT_W-1:0]  bytes_i,
  input  logic              eof_i,
  input  logic              err_i,
  output logic              load_o,
  output logic [DESC_W-1:0] desc_o,
  output logic [2:0]        status_o
);
  import txdr_pkg::*;
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_BYTES);

  logic [DESC_W-1:0] pkt_desc;
  assign pkt_desc = busy_i ? first_i : desc_i;

  always_comb begin
    load_o   = 1'b0;
    desc_o   = pkt_desc;
    status_o = ST_PKT_OK;
    if (fire_i && en_i) begin
      if (err_i) begin
        load_o   = 1'b1;
        status_o = ST_ERR_FLAG;
      end else if (bytes_i > MAX_C) begin
        load_o   = 1'b1;
        status_o = ST_ERR_SIZE;
      end else if (!mode_i) begin
        load_o = eof_i;
      end else begin
        load_o   = 1'b1;
        desc_o   = desc_i;
        status_o = !eof_i ? ST_BUF_MID : (busy_i ? ST_BUF_END : ST_BUF_ONE);
      end
    end
  end
endmodule

// File: rtl/txdr_out_reg.sv
module txdr_out_reg #(
  parameter int CH_W   = 2,
  parameter int DESC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [2:0]        status_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [DESC_W-1:0] desc_o,
  output logic [2:0]        status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      ch_o     <= '0;
      desc_o   <= '0;
      status_o <= '0;
    end else if (load_i) begin
      valid_o  <= 1'b1;
      ch_o     <= ch_i;
      desc_o   <= desc_i;
      status_o <= status_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/txdr_done_reporter.sv
module txdr_done_reporter #(
  parameter int NUM_CH    = 4,
  parameter int DESC_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 13,
  parameter int MAX_BYTES = 8188,
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic              cfg_en_i,
  input  logic              cfg_mode_i,
  input  logic              pend_valid_i,
  input  logic [CH_W-1:0]   pend_ch_i,
  input  logic [DESC_W-1:0] pend_desc_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic              pend_rst_i,
  input  logic              evt_valid_i,
  output logic              evt_ready_o,
  input  logic [CH_W-1:0]   evt_ch_i,
  input  logic [CNT_W-1:0]  evt_bytes_i,
  input  logic              evt_eof_i,
  input  logic              evt_err_i,
  output logic              done_valid_o,
  input  logic              done_ready_i,
  output logic [CH_W-1:0]   done_ch_o,
  output logic [DESC_W-1:0] done_desc_o,
  output logic [2:0]        done_status_o,
  input  logic [CH_W-1:0]   peek_ch_i,
  output logic              peek_en_o,
  output logic [ADDR_W-1:0] peek_addr_o,
  output logic [CNT_W-1:0]  peek_cnt_o
);
  logic [NUM_CH-1:0] ch_en, ch_mode, ch_busy;
  logic [DESC_W-1:0] ch_first [NUM_CH];
  logic [DESC_W-1:0] ch_desc  [NUM_CH];
  logic [ADDR_W-1:0] ch_addr  [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt   [NUM_CH];

  logic              evt_acc, ent_load;
  logic [DESC_W-1:0] ent_desc;
  logic [2:0]        ent_status;

  assign evt_ready_o = !done_valid_o || done_ready_i;
  assign evt_acc     = evt_valid_i && evt_ready_o;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    txdr_chan_state #(
      .DESC_W(DESC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)
    ) u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && cfg_ch_i == CH_W'(g)),
      .cfg_en_i   (cfg_en_i),
      .cfg_mode_i (cfg_mode_i),
      .pend_we_i  (pend_valid_i && pend_ch_i == CH_W'(g)),
      .pend_desc_i(pend_desc_i),
      .pend_addr_i(pend_addr_i),
      .pend_rst_i (pend_rst_i),
      .evt_we_i   (evt_acc && evt_ch_i == CH_W'(g)),
      .evt_bytes_i(evt_bytes_i),
      .evt_eof_i  (evt_eof_i),
      .evt_err_i  (evt_err_i),
      .en_o       (ch_en[g]),
      .mode_o     (ch_mode[g]),
      .busy_o     (ch_busy[g]),
      .first_o    (ch_first[g]),
      .desc_o     (ch_desc[g]),
      .addr_o     (ch_addr[g]),
      .cnt_o      (ch_cnt[g])
    );
  end

  txdr_entry_gen #(
    .DESC_W(DESC_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)
  ) u_gen (
    .fire_i  (evt_acc),
    .en_i    (ch_en[evt_ch_i]),
    .mode_i  (ch_mode[evt_ch_i]),
    .busy_i  (ch_busy[evt_ch_i]),
    .first_i (ch_first[evt_ch_i]),
    .desc_i  (ch_desc[evt_ch_i]),
    .bytes_i (evt_bytes_i),
    .eof_i   (evt_eof_i),
    .err_i   (evt_err_i),
    .load_o  (ent_load),
    .desc_o  (ent_desc),
    .status_o(ent_status)
  );

  txdr_out_reg #(.CH_W(CH_W), .DESC_W(DESC_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ent_load),
    .ch_i    (evt_ch_i),
    .desc_i  (ent_desc),
    .status_i(ent_status),
    .ready_i (done_ready_i),
    .valid_o (done_valid_o),
    .ch_o    (done_ch_o),
    .desc_o  (done_desc_o),
    .status_o(done_status_o)
  );

  assign peek_en_o   = ch_en[peek_ch_i];
  assign peek_addr_o = ch_addr[peek_ch_i];
  assign peek_cnt_o  = ch_cnt[peek_ch_i];
endmodule

// File: rtl/txdr_checker.sv
module txdr_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int DESC_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CH_W-1:0]   cfg_ch_i,
  input logic              pend_valid_i,
  input logic [CH_W-1:0]   pend_ch_i,
  input logic              pend_rst_i,
  input logic              evt_valid_i,
  input logic              evt_ready_o,
  input logic [CH_W-1:0]   evt_ch_i,
  input logic              evt_err_i,
  input logic              done_valid_o,
  input logic              done_ready_i,
  input logic [CH_W-1:0]   done_ch_o,
  input logic [DESC_W-1:0] done_desc_o,
  input logic [2:0]        done_status_o,
  input logic [NUM_CH-1:0] ch_en
);
  assert_hold_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o && !done_ready_i |=> done_valid_o && $stable(done_ch_o)
      && $stable(done_desc_o) && $stable(done_status_o));

  assert_ready_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o && !done_ready_i |-> !evt_ready_o);

  assert_err_disables_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_ready_o && evt_err_i && ch_en[evt_ch_i]
      && !(pend_valid_i && pend_rst_i && pend_ch_i == evt_ch_i)
      && !(cfg_we_i && cfg_ch_i == evt_ch_i)
    |=> !ch_en[$past(evt_ch_i)] && done_valid_o && done_status_o == 3'b100);

  assert_rst_enables_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_i && pend_rst_i && !(cfg_we_i && cfg_ch_i == pend_ch_i)
    |=> ch_en[$past(pend_ch_i)]);

  assert_drop_disabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_ready_o && !ch_en[evt_ch_i] |=> !done_valid_o);

  assert_status_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> done_status_o inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5});
endmodule

bind txdr_done_reporter txdr_checker #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .DESC_W(DESC_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_we_i     (cfg_we_i),
  .cfg_ch_i     (cfg_ch_i),
  .pend_valid_i (pend_valid_i),
  .pend_ch_i    (pend_ch_i),
  .pend_rst_i   (pend_rst_i),
  .evt_valid_i  (evt_valid_i),
  .evt_ready_o  (evt_ready_o),
  .evt_ch_i     (evt_ch_i),
  .evt_err_i    (evt_err_i),
  .done_valid_o (done_valid_o),
  .done_ready_i (done_ready_i),
  .done_ch_o    (done_ch_o),
  .done_desc_o  (done_desc_o),
  .done_status_o(done_status_o),
  .ch_en        (ch_en)
);

// File: tb/txdr_done_reporter_test.sv
`timescale 1ns/100ps
module txdr_done_reporter_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cfg_we = 0, cfg_en = 0, cfg_mode = 0;
  logic [1:0]  cfg_ch = 0;
  logic        pend_valid = 0, pend_rst = 0;
  logic [1:0]  pend_ch = 0;
  logic [31:0] pend_desc = 0, pend_addr = 0;
  logic        evt_valid = 0, evt_eof = 0, evt_err = 0;
  logic [1:0]  evt_ch = 0;
  logic [12:0] evt_bytes = 0;
  logic        done_ready = 1;
  logic [1:0]  peek_ch = 0;
  logic        evt_ready, done_valid, peek_en;
  logic [1:0]  done_ch;
  logic [31:0] done_desc, peek_addr;
  logic [2:0]  done_status;
  logic [12:0] peek_cnt;

  txdr_done_reporter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_en_i(cfg_en), .cfg_mode_i(cfg_mode),
    .pend_valid_i(pend_valid), .pend_ch_i(pend_ch), .pend_desc_i(pend_desc),
    .pend_addr_i(pend_addr), .pend_rst_i(pend_rst),
    .evt_valid_i(evt_valid), .evt_ready_o(evt_ready), .evt_ch_i(evt_ch),
    .evt_bytes_i(evt_bytes), .evt_eof_i(evt_eof), .evt_err_i(evt_err),
    .done_valid_o(done_valid), .done_ready_i(done_ready), .done_ch_o(done_ch),
    .done_desc_o(done_desc), .done_status_o(done_status),
    .peek_ch_i(peek_ch), .peek_en_o(peek_en), .peek_addr_o(peek_addr), .peek_cnt_o(peek_cnt)
  );

  // reference model state
  logic        m_en [NCH], m_mode [NCH], m_busy [NCH];
  logic [31:0] m_first [NCH], m_desc [NCH], m_addr [NCH];
  logic [12:0] m_cnt [NCH];
  logic        m_ov = 0;
  logic [1:0]  m_och = 0;
  logic [31:0] m_odesc = 0;
  logic [2:0]  m_ost = 0;

  int vectors = 0, fails = 0;
  string req = "R11";

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_en[c] = 0; m_mode[c] = 0; m_busy[c] = 0;
      m_first[c] = 0; m_desc[c] = 0; m_addr[c] = 0; m_cnt[c] = 0;
    end
    m_ov = 0; m_och = 0; m_odesc = 0; m_ost = 0;
  endtask

  task automatic model_edge();
    logic n_en [NCH], n_mode [NCH], n_busy [NCH];
    logic [31:0] n_first [NCH], n_addr [NCH], n_desc [NCH];
    logic [12:0] n_cnt [NCH];
    bit rdy, ld;
    logic [2:0] st;
    logic [31:0] dsc;
    int c;
    n_en = m_en; n_mode = m_mode; n_busy = m_busy; n_first = m_first;
    n_addr = m_addr; n_desc = m_desc; n_cnt = m_cnt;
    rdy = !m_ov || done_ready;
    ld = 0; st = 0; dsc = 0;
    c = int'(evt_ch);
    if (evt_valid && rdy && m_en[c]) begin
      if (evt_err || evt_bytes > 13'd8188) begin
        ld = 1; st = evt_err ? 3'd4 : 3'd5;
        dsc = m_busy[c] ? m_first[c] : m_desc[c];
        n_en[c] = 0; n_busy[c] = 0;
      end else begin
        n_cnt[c] = evt_bytes;
        n_addr[c] = m_addr[c] + 32'(evt_bytes);
        if (!m_mode[c]) begin
          if (evt_eof) begin
            ld = 1; st = 0; dsc = m_busy[c] ? m_first[c] : m_desc[c];
          end
        end else begin
          ld = 1; dsc = m_desc[c];
          st = !evt_eof ? 3'd1 : (m_busy[c] ? 3'd2 : 3'd3);
        end
        if (evt_eof) n_busy[c] = 0;
        else if (!m_busy[c]) begin n_busy[c] = 1; n_first[c] = m_desc[c]; end
      end
    end
    if (pend_valid) begin
      n_desc[pend_ch] = pend_desc; n_addr[pend_ch] = pend_addr;
      if (pend_rst) begin n_en[pend_ch] = 1; n_busy[pend_ch] = 0; end
    end
    if (cfg_we) begin n_en[cfg_ch] = cfg_en; n_mode[cfg_ch] = cfg_mode; end
    if (ld) begin m_ov = 1; m_och = evt_ch; m_odesc = dsc; m_ost = st; end
    else if (done_ready) m_ov = 0;
    m_en = n_en; m_mode = n_mode; m_busy = n_busy; m_first = n_first;
    m_addr = n_addr; m_desc = n_desc; m_cnt = n_cnt;
  endtask

  task automatic compare();
    chk("done_valid", 64'(done_valid), 64'(m_ov));
    if (m_ov) begin
      chk("done_ch", 64'(done_ch), 64'(m_och));
      chk("done_desc", 64'(done_desc), 64'(m_odesc));
      chk("done_status", 64'(done_status), 64'(m_ost));
    end
    chk("evt_ready", 64'(evt_ready), 64'(!m_ov || done_ready));
    for (int c = 0; c < NCH; c++) begin
      peek_ch = 2'(c);
      #0.1;
      chk("peek_en", 64'(peek_en), 64'(m_en[c]));
      chk("peek_addr", 64'(peek_addr), 64'(m_addr[c]));
      chk("peek_cnt", 64'(peek_cnt), 64'(m_cnt[c]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cfg_we = 0; pend_valid = 0; pend_rst = 0; evt_valid = 0; evt_err = 0; evt_eof = 0;
  endtask

  task automatic cfg(int ch, bit en, bit mode);
    cfg_we = 1; cfg_ch = 2'(ch); cfg_en = en; cfg_mode = mode; step();
  endtask

  task automatic pend(int ch, logic [31:0] d, logic [31:0] a, bit r);
    pend_valid = 1; pend_ch = 2'(ch); pend_desc = d; pend_addr = a; pend_rst = r; step();
  endtask

  task automatic evt(int ch, int bytes, bit eof, bit err);
    evt_valid = 1; evt_ch = 2'(ch); evt_bytes = 13'(bytes); evt_eof = eof; evt_err = err; step();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    req = "R11"; compare();            // reset state
    rst_n = 1;
    step();

    cfg(0, 1, 0); cfg(1, 1, 1); cfg(2, 1, 0); cfg(3, 0, 1);

    req = "R2";                         // multi-buffer packet reports first descriptor
    pend(0, 32'hA000, 32'h1000, 0); evt(0, 100, 0, 0);
    pend(0, 32'hB000, 32'h2000, 0); evt(0, 200, 0, 0);
    pend(0, 32'hC000, 32'h3000, 0); evt(0, 50, 1, 0);
    step();
    req = "R1";                         // single-buffer packet, status 000
    pend(0, 32'hD000, 32'h4000, 0); evt(0, 64, 1, 0);
    step();

    req = "R3";                         // 001, 010, 011 codes
    pend(1, 32'hE000, 32'h5000, 0); evt(1, 10, 0, 0);
    pend(1, 32'hE100, 32'h5100, 0); evt(1, 20, 1, 0);
    pend(1, 32'hE200, 32'h5200, 0); evt(1, 30, 1, 0);

    req = "R4";                         // boundary 8188 stored, 8189 rejected
    pend(1, 32'hE300, 32'hFFFF_F000, 0); evt(1, 8188, 1, 0);
    pend(2, 32'hF000, 32'h6000, 0); evt(2, 8189, 0, 0); evt(2, 12, 1, 0);
    req = "R5";                         // address wrap on advance
    pend(1, 32'hE400, 32'hFFFF_FFF0, 0); evt(1, 32, 0, 0);

    req = "R6";                         // error mid-packet reports first descriptor
    pend(1, 32'hE500, 32'h7000, 0); evt(1, 8191, 1, 1);
    req = "R8";                         // disabled channel drops events
    evt(1, 40, 1, 0); evt(3, 40, 1, 0); step();
    req = "R7";                         // reset request re-enables
    pend(1, 32'hE600, 32'h8000, 1); evt(1, 16, 1, 0);
    pend(0, 32'hAA00, 32'h9000, 0); evt(0, 8, 0, 0);
    pend(0, 32'hAB00, 32'h9100, 1); evt(0, 8, 1, 0);

    req = "R9";                         // stall holds entry and blocks events
    done_ready = 0;
    evt(1, 4, 0, 0);
    for (int i = 0; i < 4; i++) begin
      evt_valid = 1; evt_ch = 1; evt_bytes = 5; evt_eof = 1; step();
    end
    done_ready = 1;
    evt(1, 5, 1, 0); step();

    req = "R10";                        // same-cycle collisions
    evt_valid = 1; evt_ch = 0; evt_bytes = 3; evt_err = 1;
    pend(0, 32'hAC00, 32'hA000, 1);
    cfg_we = 1; cfg_ch = 2; cfg_en = 0; cfg_mode = 0;
    pend(2, 32'hF100, 32'hB000, 1);
    evt_valid = 1; evt_ch = 0; evt_bytes = 7; evt_eof = 1;
    pend(0, 32'hAD00, 32'hC000, 0);
    step();

    for (int i = 0; i < 6000; i++) begin  // R10 random collisions with backpressure
      done_ready = ($urandom % 4) != 0;
      if ($urandom % 16 == 0) begin
        cfg_we = 1; cfg_ch = 2'($urandom); cfg_en = ($urandom % 4) != 0; cfg_mode = 1'($urandom);
      end
      if ($urandom % 3 == 0) begin
        pend_valid = 1; pend_ch = 2'($urandom); pend_desc = $urandom; pend_addr = $urandom;
        pend_rst = ($urandom % 5) == 0;
      end
      if ($urandom % 2 == 0) begin
        evt_valid = 1; evt_ch = 2'($urandom); evt_eof = ($urandom % 3) == 0;
        evt_err = ($urandom % 20) == 0;
        evt_bytes = ($urandom % 10 == 0) ? 13'(8186 + $urandom % 6) : 13'($urandom % 1500);
      end
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule